// File: doc/BRIEF.md
# Bit-Serial Hypercube Lane Routing Pipeline

This block is a fixed, lock-step exchange network for a wide SIMD array. Each of `LANES` lanes (a power of two, 16 by default) presents one message bit per clock. The bits march through `STAGES = log2(LANES)` registered stages. At every stage a lane either keeps its own bit or takes the bit of its hypercube partner: the lane whose index differs from its own in exactly one index bit. Each stage has one switch bit per lane, loaded beforehand. Once the switches are set, a multi-bit message streams through one bit per cycle. No lane ever holds a whole word in flight.

A direction input picks the order in which pair distances are visited. Forward order goes from the largest distance to the smallest, which is the order a bitonic merge on a hypercube needs. Reverse order goes from the smallest distance to the largest, which suits broadcast and flood-fill.

A small controller has two states. `ST_IDLE` means no valid bit is in the stage registers. `ST_FLOW` means at least one valid bit is in flight. The transition `GO_FLOW` is taken from `ST_IDLE` when a valid bit enters. The transition `DRAIN` returns to `ST_IDLE` once neither the input nor any stage except the last holds a valid bit. In `ST_FLOW` the latched direction is held and switch writes are dropped.

Top module: `hcube_router`

## Requirements
- R1: A synchronous active-high `rst` clears every stage register, so `out_valid` and `out_bits` read 0 on the cycle after reset. It also clears all switch bits, which turns every stage into a pass-through (`out_bits` equals the `in_bits` presented `STAGES` cycles earlier).
- R2: `out_valid` is high exactly `STAGES` clock cycles after `in_valid` was high, and only for one cycle per entered bit.
- R3: With `dir_rev` = 0, stage position k (k = 0 first) pairs lane i with lane i XOR 2^(STAGES-1-k). For 16 lanes the distances are 8, 4, 2, 1.
- R4: With `dir_rev` = 1, stage position k pairs lane i with lane i XOR 2^k. For 16 lanes the distances are 1, 2, 4, 8.
- R5: At stage position k, lane i outputs its partner's bit when switch bit i of row k is 1, and keeps its own bit otherwise. Setting both bits of a pair swaps the two lanes; setting only one copies a bit.
- R6: A pulse on `cfg_we` writes `cfg_data` into switch row `cfg_stage`, where bit i is lane i's switch for stage position `cfg_stage`. The row is indexed by pipeline position, not by distance.
- R7: A write with `cfg_we` is ignored while the controller is in `ST_FLOW`.
- R8: `dir_rev` is taken live in `ST_IDLE` and latched. While in `ST_FLOW`, changes on `dir_rev` have no effect on bits in flight or entering.
- R9: Bits entered on consecutive cycles are routed independently and leave on consecutive cycles in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Switch row write strobe |
| cfg_stage | input | STAGE_W | Stage position of the row to write |
| cfg_data | input | LANES | Switch bits of the row, bit i for lane i |
| dir_rev | input | 1 | 0 = forward order, 1 = reverse order |
| in_valid | input | 1 | Entering bit slice is valid |
| in_bits | input | LANES | One message bit per lane |
| out_valid | output | 1 | Leaving bit slice is valid |
| out_bits | output | LANES | Routed message bit per lane |

## Verification
The hardest case to reach from the ports is a switch write or a direction change that lands while a message is still in the stages. There the ignored request leaves no direct trace; it only shows in the routing of later bits. The stimulus streams three back-to-back bits through a half-swapping configuration. While the first bit is inside the network, it clears that switch row and flips the direction. The later bits must still come out half-swapped, and a fresh bit sent after the pipeline drains must also come out half-swapped, which exposes any write that slipped through.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FLOW = 1'b1
    } flow_state_t;

endpackage

// File: rtl/hcr_cfg_bank.sv
module hcr_cfg_bank #(
    parameter int LANES   = 16,
    parameter int STAGES  = 4,
    parameter int STAGE_W = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           busy,
    input  logic [STAGE_W-1:0]             wr_row,
    input  logic [LANES-1:0]               wr_bits,
    output logic [STAGES-1:0][LANES-1:0]   rows
);

    logic [STAGES-1:0][LANES-1:0] rows_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_q <= '0;
        end else if (wr_en && !busy && (int'(wr_row) < STAGES)) begin
            rows_q[wr_row] <= wr_bits;
        end
    end

    assign rows = rows_q;

    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rows_q));

endmodule

// File: rtl/hcr_stage.sv
module hcr_stage #(
    parameter int LANES    = 16,
    parameter int FWD_DIST = 8,
    parameter int REV_DIST = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rev,
    input  logic [LANES-1:0] sw,
    input  logic             v_i,
    input  logic [LANES-1:0] d_i,
    output logic             v_o,
    output logic [LANES-1:0] d_o
);

    logic [LANES-1:0] mixed;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int PF = i ^ FWD_DIST;
        localparam int PR = i ^ REV_DIST;
        logic partner;
        always_comb begin
            partner  = rev ? d_i[PR] : d_i[PF];
            mixed[i] = sw[i] ? partner : d_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o <= 1'b0;
            d_o <= '0;
        end else begin
            v_o <= v_i;
            d_o <= mixed;
        end
    end

    // R2
    valid_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        v_i |=> v_o);

    // R2
    valid_hole_chk: assert property (@(posedge clk) disable iff (rst)
        !v_i |=> !v_o);

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (sw == '0) |=> (d_o == $past(d_i)));

endmodule

// File: rtl/hcr_ctrl.sv
module hcr_ctrl
    import hcr_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] entering,
    input  logic              dir_in,
    output logic              busy,
    output logic              dir_eff,
    output flow_state_t       state
);

    flow_state_t state_q;
    flow_state_t state_d;
    logic        dir_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (|entering)  state_d = ST_FLOW;   // GO_FLOW
            ST_FLOW: if (!(|entering)) state_d = ST_IDLE; // DRAIN
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_eff;
        end
    end

    always_comb begin
        busy    = 1'b0;
        dir_eff = dir_q;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                dir_eff = dir_in;
            end
            ST_FLOW: begin
                busy    = 1'b1;
                dir_eff = dir_q;
            end
            default: begin
                busy    = 1'b0;
                dir_eff = dir_q;
            end
        endcase
    end

    assign state = state_q;

    // R8
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLOW) |-> (dir_eff == dir_q));

endmodule

// File: rtl/hcube_router.sv
module hcube_router
    import hcr_pkg::*;
#(
    parameter int LANES   = 16,
    localparam int STAGES  = $clog2(LANES),
    localparam int STAGE_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [STAGE_W-1:0] cfg_stage,
    input  logic [LANES-1:0]   cfg_data,
    input  logic               dir_rev,
    input  logic               in_valid,
    input  logic [LANES-1:0]   in_bits,
    output logic               out_valid,
    output logic [LANES-1:0]   out_bits
);

    logic [STAGES:0]              v_chain;
    logic [STAGES:0][LANES-1:0]   d_chain;
    logic [STAGES-1:0][LANES-1:0] sw_rows;
    logic                         busy;
    logic                         dir_eff;
    flow_state_t                  state;

    assign v_chain[0] = in_valid;
    assign d_chain[0] = in_bits;

    hcr_ctrl #(
        .STAGES (STAGES)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .entering (v_chain[STAGES-1:0]),
        .dir_in   (dir_rev),
        .busy     (busy),
        .dir_eff  (dir_eff),
        .state    (state)
    );

    hcr_cfg_bank #(
        .LANES   (LANES),
        .STAGES  (STAGES),
        .STAGE_W (STAGE_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .busy    (busy),
        .wr_row  (cfg_stage),
        .wr_bits (cfg_data),
        .rows    (sw_rows)
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        hcr_stage #(
            .LANES    (LANES),
            .FWD_DIST (1 << (STAGES - 1 - k)),
            .REV_DIST (1 << k)
        ) u_stage (
            .clk (clk),
            .rst (rst),
            .rev (dir_eff),
            .sw  (sw_rows[k]),
            .v_i (v_chain[k]),
            .d_i (d_chain[k]),
            .v_o (v_chain[k+1]),
            .d_o (d_chain[k+1])
        );
    end

    assign out_valid = v_chain[STAGES];
    assign out_bits  = d_chain[STAGES];

    // R2
    out_in_flow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (state == ST_FLOW));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_bits == '0)));

endmodule

// File: tb/hcube_router_test.sv
module hcube_router_test;

    localparam int LANES = 16;

    typedef struct packed {
        logic        dir;
        logic [63:0] rows;
        logic [15:0] din;
        logic [15:0] dout;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{dir: 1'b0, rows: 64'h0000_0000_0000_0000, din: 16'hA5C3, dout: 16'hA5C3},
        '{dir: 1'b0, rows: 64'hFFFF_FFFF_FFFF_FFFF, din: 16'h0001, dout: 16'h8000},
        '{dir: 1'b1, rows: 64'hFFFF_FFFF_FFFF_FFFF, din: 16'h00F0, dout: 16'h0F00},
        '{dir: 1'b0, rows: 64'h0000_0000_0000_FFFF, din: 16'h1234, dout: 16'h3412},
        '{dir: 1'b1, rows: 64'h0000_0000_0000_FFFF, din: 16'h1234, dout: 16'h2138},
        '{dir: 1'b1, rows: 64'hFF00_00F0_000C_0002, din: 16'h0001, dout: 16'hFFFF},
        '{dir: 1'b1, rows: 64'hFF00_00F0_000C_0002, din: 16'hFFFE, dout: 16'h0000},
        '{dir: 1'b0, rows: 64'hAAAA_CCCC_F0F0_FF00, din: 16'h0001, dout: 16'hFFFF},
        '{dir: 1'b0, rows: 64'h0001_0000_0000_0000, din: 16'h0002, dout: 16'h0003}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_stage = '0;
    logic [LANES-1:0] cfg_data = '0;
    logic             dir_rev = 1'b0;
    logic             in_valid = 1'b0;
    logic [LANES-1:0] in_bits = '0;
    logic             out_valid;
    logic [LANES-1:0] out_bits;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hcube_router #(.LANES(LANES)) uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_stage (cfg_stage),
        .cfg_data  (cfg_data),
        .dir_rev   (dir_rev),
        .in_valid  (in_valid),
        .in_bits   (in_bits),
        .out_valid (out_valid),
        .out_bits  (out_bits)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_row(input logic [1:0] k, input logic [15:0] bits);
        cfg_we    = 1'b1;
        cfg_stage = k;
        cfg_data  = bits;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic send_one(input logic dir, input logic [15:0] din,
                            input logic [15:0] dout, input string tag);
        dir_rev  = dir;
        in_valid = 1'b1;
        in_bits  = din;
        @(negedge clk);
        in_valid = 1'b0;
        in_bits  = '0;
        repeat (2) @(negedge clk);
        check({tag, " R2 early valid"}, {15'd0, out_valid}, 16'd0);
        @(negedge clk);
        check({tag, " R2 valid at latency"}, {15'd0, out_valid}, 16'd1);
        check({tag, " data"}, out_bits, dout);
        @(negedge clk);
        check({tag, " R2 single valid"}, {15'd0, out_valid}, 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 reset out_valid", {15'd0, out_valid}, 16'd0);
        check("R1 reset out_bits", out_bits, 16'h0000);
        // R1: cleared switches pass through
        send_one(1'b0, 16'h5A3C, 16'h5A3C, "R1 cleared pass");

        // R3 R4 R5 R6: table walk
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 4; k++) write_row(2'(k), TBL[v].rows[k*16 +: 16]);
            send_one(TBL[v].dir, TBL[v].din, TBL[v].dout,
                     $sformatf("R3/R4/R5/R6 vec%0d", v));
        end

        // R9 R7 R8: stream of three bits, late write and direction flip ignored
        for (int k = 0; k < 4; k++) write_row(2'(k), (k == 0) ? 16'hFFFF : 16'h0000);
        dir_rev = 1'b0; in_valid = 1'b1; in_bits = 16'h1234;
        @(negedge clk);
        in_bits = 16'hABCD; cfg_we = 1'b1; cfg_stage = 2'd0; cfg_data = 16'h0000;
        dir_rev = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; in_bits = 16'h00FF;
        @(negedge clk);
        in_valid = 1'b0; in_bits = '0;
        @(negedge clk);
        check("R9 stream bit0", out_bits, 16'h3412);
        @(negedge clk);
        check("R8 stream bit1 dir held", out_bits, 16'hCDAB);
        check("R9 stream bit1 valid", {15'd0, out_valid}, 16'd1);
        @(negedge clk);
        check("R7 stream bit2 cfg held", out_bits, 16'hFF00);
        dir_rev = 1'b0;
        @(negedge clk);
        check("R9 stream end", {15'd0, out_valid}, 16'd0);
        // R7: the dropped write must not have reached the switch row
        send_one(1'b0, 16'h1234, 16'h3412, "R7 after drain");

        // R1: reset in the middle of a message
        in_valid = 1'b1; in_bits = 16'hFFFF;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset valid", {15'd0, out_valid}, 16'd0);
        check("R1 mid reset bits", out_bits, 16'h0000);
        @(negedge clk);
        check("R1 flushed bit gone", {15'd0, out_valid}, 16'd0);
        send_one(1'b0, 16'h1234, 16'h1234, "R1 cfg cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule